// File: doc/BRIEF.md
# Buffered Configuration-Port Transfer Engine

This block sits on a simple word-wide host bus and fronts a 32-bit configuration port. It holds a 512-word buffer RAM. The host reaches the buffer through a word window at the low byte addresses. When the engine is idle, the host fills the buffer with configuration words or collects words that were read back.

To run a transfer, the host loads a length in bytes and a starting buffer word. It then writes a direction register. That write both picks the direction and launches the move. In the configure direction, words stream from the buffer to the port. In the readback direction, words taken from the port land in the buffer. A status word packs four things: the completion flag, a block of constant ones, a readback-busy flag, and three flags sampled from the configuration side. Writing the status address stops everything at once.

The port uses valid/ready handshakes in both directions. The buffer pointer advances only on an accepted word. A prefetch path lets a configure transfer move one word per clock while the receiver stays ready.

Top module: `cfg_xfer_engine`

## Requirements
- R1: While idle, a host write to byte address N*4 (bit 11 clear, bits 1:0 zero) stores the word in buffer entry N. A later host read of that address returns it with host_rvalid one cycle after the request.
- R2: The length register (0x800) and the start-word register (0x804) read back the last value written. The direction register (0x808) reads as zero.
- R3: Writing 0x808 with bit 0 = 0 while idle sends buffer words start..start+len/4-1 out on cfg_out, in ascending order, one per handshake.
- R4: Writing 0x808 with bit 0 = 1 while idle stores len/4 words accepted on cfg_in into the buffer, from the start word upward.
- R5: The status word (0x80C) has this layout. Bit 0 is 1 when idle and 0 while a transfer runs. Bits 4:1 read as 1. Bit 5 mirrors cfg_abort_n. Bit 6 is 1 only during readback. Bit 7 mirrors cfg_aligned. Bit 8 mirrors cfg_err. Bits 31:9 read as 0. While idle, cfg_out_valid and cfg_in_ready are low.
- R6: While cfg_out_valid is high and cfg_out_ready is low, cfg_out_valid stays high and cfg_out_data holds. No word is lost or repeated under stalls.
- R7: With cfg_out_ready held high, the handshakes of a configure transfer occur on consecutive clocks.
- R8: A direction write with len/4 = 0, or with start + len/4 > 512, starts nothing. Done stays 1 and no word moves on the port.
- R9: A direction write during a running transfer is ignored. The running transfer keeps its direction.
- R10: Any write to 0x80C aborts a running transfer. In the next cycle the engine is idle, with cfg_out_valid low and done set.
- R11: While a transfer runs, host reads of the buffer window return 0 and host writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte address. Bit 11 selects registers, which also need bits 10:4 zero. Bits 1:0 must be zero or the access is ignored |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High one cycle after a read request |
| cfg_out_valid | output | 1 | Configure word available |
| cfg_out_ready | input | 1 | Port accepts configure word |
| cfg_out_data | output | 32 | Configure word |
| cfg_in_valid | input | 1 | Readback word available |
| cfg_in_ready | output | 1 | Engine accepts readback word |
| cfg_in_data | input | 32 | Readback word |
| cfg_abort_n | input | 1 | Active-low abort flag from the port side |
| cfg_aligned | input | 1 | Data-aligned flag from the port side |
| cfg_err | input | 1 | Configuration error flag |

## Verification
A wrong transfer counter shows up in two ways. The port may carry one word too many or too few. Or the done bit may rise before or after the last handshake, which a status poll reveals within a few cycles. A broken prefetch queue shows at the port within the next handshake: a repeated or skipped word, a data change during a stall, or a gap in the otherwise back-to-back stream. A bad pointer or a bad RAM arbitration only shows later, as a wrong word returned in a buffer read-back once the transfer has ended.

// File: rtl/cfg_xfer_pkg.sv
package cfg_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_CFG  = 2'd1,
    XS_RDB  = 2'd2
  } xfer_state_e;

  typedef enum logic [1:0] {
    RS_LEN   = 2'd0,
    RS_START = 2'd1,
    RS_DIR   = 2'd2,
    RS_STAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_ONES_W = 4;
endpackage

// File: rtl/xfer_buf_ram.sv
module xfer_buf_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs
  import cfg_xfer_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned HAW  = AW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic           host_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  input  logic           busy,
  input  logic           rb_active,
  input  logic           abort_n_i,
  input  logic           aligned_i,
  input  logic           err_i,
  input  logic [DW-1:0]  ram_rdata,
  output logic [DW-1:0]  len_q,
  output logic [DW-1:0]  start_q,
  output logic           go_req,
  output logic           go_dir,
  output logic           kill_req,
  output logic           hram_en,
  output logic           hram_we,
  output logic [AW-1:0]  hram_addr,
  output logic [DW-1:0]  hram_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid
);
  logic           word_ok, in_regs, in_buf, reg_hit, wr_hit, rd_fire;
  reg_sel_e       sel;
  logic [DW-1:0]  stat_word, reg_rd;
  logic           len_en, start_en;
  logic           rvalid_d, rvalid_q, from_ram_d, from_ram_q;
  logic [DW-1:0]  rreg_d, rreg_q;

  always_comb begin
    word_ok   = (host_addr[1:0] == 2'b00);
    in_regs   = host_addr[HAW-1];
    in_buf    = !in_regs && word_ok;
    reg_hit   = in_regs && word_ok && (host_addr[HAW-2:4] == '0);
    sel       = reg_sel_e'(host_addr[3:2]);
    wr_hit    = host_req && host_wr && reg_hit;
    rd_fire   = host_req && !host_wr;
    len_en    = wr_hit && (sel == RS_LEN);
    start_en  = wr_hit && (sel == RS_START);
    go_req    = wr_hit && (sel == RS_DIR);
    go_dir    = host_wdata[0];
    kill_req  = wr_hit && (sel == RS_STAT);
    hram_en   = host_req && in_buf && !busy;
    hram_we   = host_wr;
    hram_addr = host_addr[AW+1:2];
    hram_wdata = host_wdata;

    stat_word = '0;
    stat_word[0] = !busy;
    stat_word[STAT_ONES_W:1] = '1;
    stat_word[5] = abort_n_i;
    stat_word[6] = rb_active;
    stat_word[7] = aligned_i;
    stat_word[8] = err_i;

    unique case (sel)
      RS_LEN:   reg_rd = len_q;
      RS_START: reg_rd = start_q;
      RS_DIR:   reg_rd = '0;
      default:  reg_rd = stat_word;
    endcase

    rvalid_d   = rd_fire;
    from_ram_d = rd_fire && in_buf && !busy;
    rreg_d     = (rd_fire && reg_hit) ? reg_rd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q      <= '0;
      start_q    <= '0;
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      rreg_q     <= '0;
    end else begin
      if (len_en)   len_q   <= host_wdata;
      if (start_en) start_q <= host_wdata;
      rvalid_q   <= rvalid_d;
      from_ram_q <= from_ram_d;
      rreg_q     <= rreg_d;
    end
  end

  assign host_rdata  = from_ram_q ? ram_rdata : rreg_q;
  assign host_rvalid = rvalid_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import cfg_xfer_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_req,
  input  logic          go_dir,
  input  logic          kill_req,
  input  logic [DW-3:0] words_i,
  input  logic [DW-1:0] start_i,
  input  logic          out_ready,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] ram_rdata,
  output logic          busy,
  output logic          rb_active,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          in_ready,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  xfer_state_e   state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] issue_left_q, issue_left_d, move_left_q, move_left_d;
  logic          fly_q, fly_d;
  logic          v0_q, v0_d, v1_q, v1_d;
  logic [DW-1:0] d0_q, d0_d, d1_q, d1_d;
  logic [DW:0]   end_word;
  logic          go_ok, pop, issue, accept;
  logic [1:0]    fill;
  logic          v0a, v1a;
  logic [DW-1:0] d0a;

  always_comb begin
    end_word = {3'b000, words_i} + {1'b0, start_i};
    go_ok    = (words_i != '0) && (end_word <= (DW+1)'(DEPTH));
    pop      = v0_q && out_ready;
    fill     = 2'(v0_q) + 2'(v1_q) + 2'(fly_q) - 2'(pop);
    issue    = (state_q == XS_CFG) && (issue_left_q != '0) && (fill < 2'd2);
    in_ready = (state_q == XS_RDB);
    accept   = in_valid && in_ready;

    ram_en    = issue || accept;
    ram_we    = accept;
    ram_addr  = ptr_q;
    ram_wdata = in_data;

    v0a = pop ? v1_q : v0_q;
    d0a = pop ? d1_q : d0_q;
    v1a = pop ? 1'b0 : v1_q;

    state_d      = state_q;
    ptr_d        = ptr_q;
    issue_left_d = issue_left_q;
    move_left_d  = move_left_q;
    fly_d        = 1'b0;
    v0_d = 1'b0; v1_d = 1'b0; d0_d = d0_q; d1_d = d1_q;

    unique case (state_q)
      XS_IDLE: begin
        if (go_req && go_ok) begin
          state_d      = go_dir ? XS_RDB : XS_CFG;
          ptr_d        = start_i[AW-1:0];
          issue_left_d = words_i[CW-1:0];
          move_left_d  = words_i[CW-1:0];
        end
      end
      XS_CFG: begin
        v0_d = v0a; d0_d = d0a; v1_d = v1a;
        if (fly_q) begin
          if (!v0a) begin v0_d = 1'b1; d0_d = ram_rdata; end
          else      begin v1_d = 1'b1; d1_d = ram_rdata; end
        end
        fly_d = issue;
        if (issue) begin
          ptr_d        = ptr_q + 1'b1;
          issue_left_d = issue_left_q - 1'b1;
        end
        if (pop) begin
          move_left_d = move_left_q - 1'b1;
          if (move_left_q == CW'(1)) state_d = XS_IDLE;
        end
      end
      XS_RDB: begin
        if (accept) begin
          ptr_d       = ptr_q + 1'b1;
          move_left_d = move_left_q - 1'b1;
          if (move_left_q == CW'(1)) state_d = XS_IDLE;
        end
      end
      default: state_d = XS_IDLE;
    endcase

    if (kill_req) begin
      state_d      = XS_IDLE;
      issue_left_d = '0;
      move_left_d  = '0;
      fly_d = 1'b0; v0_d = 1'b0; v1_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= XS_IDLE;
      ptr_q        <= '0;
      issue_left_q <= '0;
      move_left_q  <= '0;
      fly_q        <= 1'b0;
      v0_q <= 1'b0; v1_q <= 1'b0;
      d0_q <= '0;   d1_q <= '0;
    end else begin
      state_q      <= state_d;
      ptr_q        <= ptr_d;
      issue_left_q <= issue_left_d;
      move_left_q  <= move_left_d;
      fly_q        <= fly_d;
      v0_q <= v0_d; v1_q <= v1_d;
      d0_q <= d0_d; d1_q <= d1_d;
    end
  end

  assign busy      = (state_q != XS_IDLE);
  assign rb_active = (state_q == XS_RDB);
  assign out_valid = v0_q;
  assign out_data  = d0_q;
endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned HAW  = AW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic           host_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic           cfg_out_valid,
  input  logic           cfg_out_ready,
  output logic [DW-1:0]  cfg_out_data,
  input  logic           cfg_in_valid,
  output logic           cfg_in_ready,
  input  logic [DW-1:0]  cfg_in_data,
  input  logic           cfg_abort_n,
  input  logic           cfg_aligned,
  input  logic           cfg_err
);
  logic          rst_s1, rst_s2;
  logic          busy, rb_active, go_req, go_dir, kill_req;
  logic [DW-1:0] len_q, start_q;
  logic          hram_en, hram_we, eram_en, eram_we, ram_en, ram_we;
  logic [AW-1:0] hram_addr, eram_addr, ram_addr;
  logic [DW-1:0] hram_wdata, eram_wdata, ram_wdata, ram_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  xfer_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s2),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy), .rb_active(rb_active),
    .abort_n_i(cfg_abort_n), .aligned_i(cfg_aligned), .err_i(cfg_err),
    .ram_rdata(ram_rdata), .len_q(len_q), .start_q(start_q),
    .go_req(go_req), .go_dir(go_dir), .kill_req(kill_req),
    .hram_en(hram_en), .hram_we(hram_we), .hram_addr(hram_addr),
    .hram_wdata(hram_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  xfer_engine #(.DEPTH(DEPTH), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_s2),
    .go_req(go_req), .go_dir(go_dir), .kill_req(kill_req),
    .words_i(len_q[DW-1:2]), .start_i(start_q),
    .out_ready(cfg_out_ready), .in_valid(cfg_in_valid), .in_data(cfg_in_data),
    .ram_rdata(ram_rdata), .busy(busy), .rb_active(rb_active),
    .out_valid(cfg_out_valid), .out_data(cfg_out_data), .in_ready(cfg_in_ready),
    .ram_en(eram_en), .ram_we(eram_we), .ram_addr(eram_addr), .ram_wdata(eram_wdata)
  );

  always_comb begin
    if (busy) begin
      ram_en = eram_en; ram_we = eram_we; ram_addr = eram_addr; ram_wdata = eram_wdata;
    end else begin
      ram_en = hram_en; ram_we = hram_we; ram_addr = hram_addr; ram_wdata = hram_wdata;
    end
  end

  xfer_buf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/cfg_xfer_checker.sv
module cfg_xfer_checker #(
  parameter int unsigned DW  = 32,
  parameter int unsigned HAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_req,
  input logic           host_wr,
  input logic [HAW-1:0] host_addr,
  input logic [DW-1:0]  host_rdata,
  input logic [DW-3:0]  words,
  input logic           busy,
  input logic           rb_active,
  input logic           cfg_out_valid,
  input logic           cfg_out_ready,
  input logic [DW-1:0]  cfg_out_data,
  input logic           cfg_in_ready
);
  logic reg_ok, dir_wr, stat_wr, buf_rd;
  assign reg_ok  = host_addr[HAW-1] && (host_addr[HAW-2:4] == '0) && (host_addr[1:0] == 2'b00);
  assign dir_wr  = host_req && host_wr && reg_ok && (host_addr[3:2] == 2'd2);
  assign stat_wr = host_req && host_wr && reg_ok && (host_addr[3:2] == 2'd3);
  assign buf_rd  = host_req && !host_wr && !host_addr[HAW-1] && (host_addr[1:0] == 2'b00);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out_valid && !cfg_out_ready && !stat_wr) |=> (cfg_out_valid && $stable(cfg_out_data)));

  a_r5_idle_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_out_valid && !cfg_in_ready));

  a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (!busy && !cfg_out_valid));

  a_r8_empty_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dir_wr && (words == '0)) |=> !busy);

  a_r9_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rb_active && dir_wr) |=> !cfg_in_ready);

  a_r11_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_rd) |=> (host_rdata == '0));
endmodule

bind cfg_xfer_engine cfg_xfer_checker #(.DW(DW), .HAW(HAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
  .host_addr(host_addr), .host_rdata(host_rdata), .words(len_q[DW-1:2]),
  .busy(busy), .rb_active(rb_active), .cfg_out_valid(cfg_out_valid),
  .cfg_out_ready(cfg_out_ready), .cfg_out_data(cfg_out_data),
  .cfg_in_ready(cfg_in_ready)
);

// File: tb/cfg_xfer_engine_tb.sv
module cfg_xfer_engine_tb;
  localparam int CLK_P = 10;
  localparam int WD    = 150000;
  localparam logic [11:0] A_LEN = 12'h800, A_START = 12'h804, A_DIR = 12'h808, A_STAT = 12'h80C;

  logic clk, rst_n;
  logic host_req, host_wr, host_rvalid;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic cfg_out_valid, cfg_out_ready, cfg_in_valid, cfg_in_ready;
  logic [31:0] cfg_out_data, cfg_in_data;
  logic cfg_abort_n, cfg_aligned, cfg_err;

  cfg_xfer_engine u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] mem_m [512];
  logic [31:0] rx_buf [512];
  logic [31:0] src [512];
  int rx_cnt = 0, first_cyc = 0, last_cyc = 0;
  int rdy_mode = 2;   // 0 always, 1 random, 2 never
  int vld_mode = 2;
  int pidx = 0, pnum = 0;

  initial begin clk = 0; forever #(CLK_P/2) clk = ~clk; end
  always @(posedge clk) cyc++;

  function automatic logic [31:0] exp_status(logic done, logic rb, logic abn, logic al, logic er);
    return {23'd0, er, al, rb, abn, 4'hF, done};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // port-side receiver
  always @(negedge clk) begin
    case (rdy_mode)
      0: cfg_out_ready = 1'b1;
      1: cfg_out_ready = ($urandom % 3) != 0;
      default: cfg_out_ready = 1'b0;
    endcase
    if (cfg_out_valid && cfg_out_ready) begin
      if (rx_cnt == 0) first_cyc = cyc;
      last_cyc = cyc;
      if (rx_cnt < 512) rx_buf[rx_cnt] = cfg_out_data;
      rx_cnt++;
    end
  end

  // port-side producer
  always @(negedge clk) begin
    if (pidx < pnum) begin
      case (vld_mode)
        0: cfg_in_valid = 1'b1;
        1: cfg_in_valid = ($urandom % 2) != 0;
        default: cfg_in_valid = 1'b0;
      endcase
      cfg_in_data = src[pidx];
    end else begin
      cfg_in_valid = 1'b0;
    end
    if (cfg_in_valid && cfg_in_ready) pidx++;
  end

  task automatic hwrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_wr = 0;
  endtask

  task automatic hread(logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_req = 1; host_wr = 0; host_addr = a;
    @(negedge clk);
    host_req = 0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic wait_done();
    logic [31:0] s; logic v;
    for (int i = 0; i < 3000; i++) begin
      hread(A_STAT, s, v);
      if (s[0]) break;
    end
  endtask

  task automatic run_cfg(int off, int n, int mode, string tag);
    int bad = 0;
    rdy_mode = mode; rx_cnt = 0;
    hwrite(A_LEN, 32'(n * 4));
    hwrite(A_START, 32'(off));
    hwrite(A_DIR, 32'd0);
    wait_done();
    chk(rx_cnt == n, {tag, " word count"}, 32'(rx_cnt), 32'(n));
    for (int k = 0; k < n && k < rx_cnt; k++) if (rx_buf[k] !== mem_m[off + k]) bad++;
    chk(bad == 0, {tag, " word order/data"}, 32'(bad), 32'd0);
    rdy_mode = 2;
  endtask

  task automatic run_rdb(int off, int n, int mode, string tag);
    logic [31:0] d; logic v; int bad = 0;
    for (int k = 0; k < n; k++) src[k] = $urandom;
    vld_mode = mode; pidx = 0; pnum = n;
    hwrite(A_LEN, 32'(n * 4));
    hwrite(A_START, 32'(off));
    hwrite(A_DIR, 32'd1);
    wait_done();
    pnum = 0;
    chk(pidx == n, {tag, " accepted count"}, 32'(pidx), 32'(n));
    for (int k = 0; k < n; k++) begin
      mem_m[off + k] = src[k];
      hread(12'(4 * (off + k)), d, v);
      if (d !== src[k]) bad++;
    end
    chk(bad == 0, {tag, " stored data"}, 32'(bad), 32'd0);
  endtask

  initial begin
    logic [31:0] d; logic v; int bad;
    void'($urandom(32'h5EED));
    host_req = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    cfg_out_ready = 0; cfg_in_valid = 0; cfg_in_data = 0;
    cfg_abort_n = 1; cfg_aligned = 0; cfg_err = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    hread(A_STAT, d, v);
    chk(d === exp_status(1, 0, 1, 0, 0), "R5 reset status", d, exp_status(1, 0, 1, 0, 0));
    chk(cfg_out_valid === 0 && cfg_in_ready === 0, "R5 reset port idle", {30'd0, cfg_out_valid, cfg_in_ready}, 0);

    // R1: fill buffer, spot-check read-back
    for (int i = 0; i < 512; i++) begin
      mem_m[i] = $urandom;
      hwrite(12'(4 * i), mem_m[i]);
    end
    hread(12'h000, d, v);
    chk(v === 1'b1, "R1 rvalid", {31'd0, v}, 1);
    chk(d === mem_m[0], "R1 word 0", d, mem_m[0]);
    hread(12'h7FC, d, v);
    chk(d === mem_m[511], "R1 word 511", d, mem_m[511]);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      int a = $urandom % 512;
      hread(12'(4 * a), d, v);
      if (d !== mem_m[a]) bad++;
    end
    chk(bad == 0, "R1 random read-back", 32'(bad), 0);

    // R2
    hwrite(A_LEN, 32'h0000_0ABC);
    hwrite(A_START, 32'h0000_0123);
    hread(A_LEN, d, v);   chk(d === 32'h0ABC, "R2 length readback", d, 32'h0ABC);
    hread(A_START, d, v); chk(d === 32'h0123, "R2 start readback", d, 32'h0123);
    hread(A_DIR, d, v);   chk(d === 32'h0, "R2 direction reads zero", d, 0);

    // R3 / R7 back-to-back
    run_cfg(5, 8, 0, "R3 directed");
    chk(last_cyc - first_cyc == 7, "R7 consecutive handshakes", 32'(last_cyc - first_cyc), 7);
    run_cfg(0, 1, 0, "R3 single word");

    // R6 stalls up to the buffer end
    run_cfg(500, 12, 1, "R6 stalled to end");

    // R5 during readback, then R4
    for (int k = 0; k < 6; k++) src[k] = $urandom;
    vld_mode = 2; pidx = 0; pnum = 6;
    hwrite(A_LEN, 32'd24); hwrite(A_START, 32'd100); hwrite(A_DIR, 32'd1);
    hread(A_STAT, d, v);
    chk(d === exp_status(0, 1, 1, 0, 0), "R5 status in readback", d, exp_status(0, 1, 1, 0, 0));
    vld_mode = 1;
    wait_done(); pnum = 0;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      mem_m[100 + k] = src[k];
      hread(12'(4 * (100 + k)), d, v);
      if (d !== src[k]) bad++;
    end
    chk(bad == 0, "R4 directed readback", 32'(bad), 0);
    run_rdb(480, 32, 0, "R4 full-rate to end");

    // R8
    rx_cnt = 0; rdy_mode = 0;
    hwrite(A_LEN, 32'd0); hwrite(A_START, 32'd0); hwrite(A_DIR, 32'd0);
    hread(A_STAT, d, v);
    chk(d[0] === 1'b1, "R8 zero length done", d, 1);
    hwrite(A_LEN, 32'd12); hwrite(A_START, 32'd510); hwrite(A_DIR, 32'd0);
    hread(A_STAT, d, v);
    chk(d[0] === 1'b1, "R8 overrun rejected", d, 1);
    repeat (5) @(negedge clk);
    chk(rx_cnt == 0, "R8 no port words", 32'(rx_cnt), 0);
    rdy_mode = 2;

    // R9, R11, R10 on a stalled transfer
    rx_cnt = 0;
    hwrite(A_LEN, 32'd256); hwrite(A_START, 32'd0); hwrite(A_DIR, 32'd0);
    hwrite(A_DIR, 32'd1);
    repeat (2) @(negedge clk);
    chk(cfg_in_ready === 0 && cfg_out_valid === 1, "R9 direction kept",
        {30'd0, cfg_in_ready, cfg_out_valid}, 32'd1);
    hread(A_STAT, d, v);
    chk(d === exp_status(0, 0, 1, 0, 0), "R9 still configuring", d, exp_status(0, 0, 1, 0, 0));
    hwrite(12'(4 * 200), 32'hDEAD_BEEF);
    hread(12'(4 * 200), d, v);
    chk(d === 32'h0, "R11 busy read zero", d, 0);
    hwrite(A_STAT, 32'h0);
    chk(cfg_out_valid === 0, "R10 port quiet after abort", {31'd0, cfg_out_valid}, 0);
    hread(A_STAT, d, v);
    chk(d[0] === 1'b1, "R10 done after abort", d, 1);
    hread(12'(4 * 200), d, v);
    chk(d === mem_m[200], "R11 busy write dropped", d, mem_m[200]);

    // R5 input flags
    cfg_abort_n = 0; cfg_aligned = 1; cfg_err = 1;
    hread(A_STAT, d, v);
    chk(d === exp_status(1, 0, 0, 1, 1), "R5 flag bits", d, exp_status(1, 0, 0, 1, 1));
    cfg_abort_n = 1; cfg_aligned = 0; cfg_err = 0;

    // random mix
    for (int t = 0; t < 10; t++) begin
      int n = 1 + $urandom % 40;
      int off = $urandom % (513 - n);
      if ($urandom % 2) run_cfg(off, n, 1, "R3 random configure");
      else              run_rdb(off, n, 1, "R4 random readback");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule